// File: doc/BRIEF.md
# Link Power Monitor and Wake Signaller

This block sits in the physical-layer clock domain and tracks whether the attached link-layer controller has power. It reads a raw power-status level from the link through a two-stage synchroniser. It then filters that level in a deliberately lopsided way. A single high sample is enough to declare the link powered. A low level must persist for a long, parameterised run of cycles before the link is declared unpowered. While the link is unpowered, the link interface is disabled and the node is flagged as able to act only as a repeater.

A single pin is shared between a board strap and a wake output. While hardware reset is asserted, the pin driver is off and the block samples the pin as the default contender bit. It also samples a three-bit power-class strap in the same way. Once reset is released, the block drives the pin. On a one-cycle wake request, issued only while the link is unpowered, it emits a square wave of eight clock cycles (four high, four low) to ask the link to power up. The wave stops when the link comes up or when a cancel pulse arrives. It is held low whenever the synchronised power-status level is high.

Top module: `link_power_monitor`

## Requirements
- R1: `link_powered` falls at the clock edge that registers the DOWN_CYCLES-th consecutive low synchronised sample. Any high sample restarts the low count, so a low run of DOWN_CYCLES-1 input cycles never clears the flag.
- R2: After `lps_in` rises (driven between edges), `link_powered` is still 0 after the next two clock edges and is 1 after the third.
- R3: `link_if_en` equals `link_powered` and `repeater_only` equals its inverse at all times.
- R4: A `wake_req` pulse taken while `link_powered` is 0 starts the wave. `wake_out` is 1 for the HALF_PERIOD=4 cycles that follow that edge, then 0 for 4 cycles, repeating with period 8. A `wake_req` while `link_powered` is 1 is ignored.
- R5: `wake_out` is 0 from the second clock edge after `lps_in` rises, whatever the wave phase.
- R6: A `wake_cancel` pulse stops the wave. `wake_out` is 0 after the next edge and stays 0.
- R7: `contender_dflt` holds the value of `wake_pin_in` sampled while `rst_n` is 0, and later changes on the pin do not alter it.
- R8: `pwr_class_dflt` holds the value of `pwr_class_strap` sampled while `rst_n` is 0, and later strap changes do not alter it.
- R9: `wake_oe` is 0 while `rst_n` is 0 and is 1 from the first edge after release. `link_powered` is 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Physical-layer clock |
| rst_n | input | 1 | Hardware reset, active low |
| lps_in | input | 1 | Raw link power-status level (asynchronous) |
| wake_req | input | 1 | One-cycle request to start the wake wave |
| wake_cancel | input | 1 | One-cycle request to stop the wake wave |
| wake_pin_in | input | 1 | Pad input of the shared strap/wake pin |
| pwr_class_strap | input | 3 | Power-class strap pins |
| wake_out | output | 1 | Wake wave driven onto the shared pin |
| wake_oe | output | 1 | Output enable of the shared pin |
| link_powered | output | 1 | Filtered link power state |
| link_if_en | output | 1 | Link interface enabled |
| repeater_only | output | 1 | Only repeater operation is available |
| contender_dflt | output | 1 | Contender bit captured in reset |
| pwr_class_dflt | output | 3 | Power-class code captured in reset |

## Verification
A low-time counter that is off by one shows up as `link_powered` falling one edge early or late after a long low run. A counter that is not restarted by a high sample clears the flag after a short glitch train. Both effects appear within DOWN_CYCLES+2 edges of the stimulus. A wrong wave phase or state shows on `wake_out` within one 8-cycle period, as a high run of the wrong length or as a pulse that survives a cancel or a rising power-status level. Strap registers that keep sampling after reset show as a changed default within one edge of a strap change.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int PCLASS_W = 3;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_RUN  = 1'b1
    } wake_state_e;

    typedef struct packed {
        logic                contender;
        logic [PCLASS_W-1:0] pclass;
    } strap_t;

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/lpm_filter.sv
module lpm_filter #(
    parameter int DOWN_CYCLES = 1228800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_s,
    output logic powered
);

    localparam int CNT_W = $clog2(DOWN_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_LOW = CNT_W'(DOWN_CYCLES - 1);

    typedef struct packed {
        logic             powered;
        logic [CNT_W-1:0] low_cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lps_s) begin
            st_d.powered = 1'b1;
            st_d.low_cnt = '0;
        end else if (st_q.powered) begin
            if (st_q.low_cnt == LAST_LOW) begin
                st_d.powered = 1'b0;
                st_d.low_cnt = '0;
            end else begin
                st_d.low_cnt = st_q.low_cnt + 1'b1;
            end
        end else begin
            st_d.low_cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign powered = st_q.powered;

endmodule

// File: rtl/lpm_wake.sv
module lpm_wake
    import lpm_pkg::*;
#(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_s,
    input  logic powered,
    input  logic req,
    input  logic cancel,
    output logic wake
);

    localparam int PERIOD = 2 * HALF_PERIOD;
    localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF_PERIOD);

    typedef struct packed {
        wake_state_e      st;
        logic [PH_W-1:0]  phase;
    } wake_t;

    wake_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        case (w_q.st)
            WK_IDLE: begin
                w_d.phase = '0;
                if (req && !powered) w_d.st = WK_RUN;
            end
            WK_RUN: begin
                if (cancel || powered) begin
                    w_d.st    = WK_IDLE;
                    w_d.phase = '0;
                end else if (w_q.phase == PH_LAST) begin
                    w_d.phase = '0;
                end else begin
                    w_d.phase = w_q.phase + 1'b1;
                end
            end
            default: begin
                w_d.st    = WK_IDLE;
                w_d.phase = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{st: WK_IDLE, phase: '0};
        else        w_q <= w_d;
    end

    assign wake = (w_q.st == WK_RUN) && (w_q.phase < PH_HALF) && !lps_s;

endmodule

// File: rtl/lpm_strap.sv
module lpm_strap
    import lpm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin_in,
    input  logic [PCLASS_W-1:0] pclass_in,
    output strap_t              strap,
    output logic                drive_en
);

    strap_t cap_d, cap_q;
    logic   en_d, en_q;

    always_comb begin
        cap_d = cap_q;
        if (!rst_n) begin
            cap_d.contender = pin_in;
            cap_d.pclass    = pclass_in;
        end
        en_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign strap    = cap_q;
    assign drive_en = en_q;

endmodule

// File: rtl/link_power_monitor.sv
module link_power_monitor
    import lpm_pkg::*;
#(
    parameter int DOWN_CYCLES = 1228800,
    parameter int HALF_PERIOD = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lps_in,
    input  logic                wake_req,
    input  logic                wake_cancel,
    input  logic                wake_pin_in,
    input  logic [PCLASS_W-1:0] pwr_class_strap,
    output logic                wake_out,
    output logic                wake_oe,
    output logic                link_powered,
    output logic                link_if_en,
    output logic                repeater_only,
    output logic                contender_dflt,
    output logic [PCLASS_W-1:0] pwr_class_dflt
);

    logic   lps_sync;
    logic   powered;
    strap_t strap;

    lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (lps_in),
        .sync_out (lps_sync)
    );

    lpm_filter #(.DOWN_CYCLES(DOWN_CYCLES)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .lps_s   (lps_sync),
        .powered (powered)
    );

    lpm_wake #(.HALF_PERIOD(HALF_PERIOD)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .lps_s   (lps_sync),
        .powered (powered),
        .req     (wake_req),
        .cancel  (wake_cancel),
        .wake    (wake_out)
    );

    lpm_strap u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (wake_pin_in),
        .pclass_in (pwr_class_strap),
        .strap     (strap),
        .drive_en  (wake_oe)
    );

    assign link_powered   = powered;
    assign link_if_en     = powered;
    assign repeater_only  = ~powered;
    assign contender_dflt = strap.contender;
    assign pwr_class_dflt = strap.pclass;

endmodule

// File: rtl/link_power_monitor_chk.sv
module link_power_monitor_chk #(
    parameter int DOWN_CYCLES = 1228800,
    parameter int HALF_PERIOD = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lps_s,
    input logic       link_powered,
    input logic       link_if_en,
    input logic       repeater_only,
    input logic       wake_out,
    input logic       contender_dflt,
    input logic [2:0] pwr_class_dflt
);

    localparam int LR_W = $clog2(DOWN_CYCLES + 2);
    localparam int HR_W = $clog2(HALF_PERIOD + 2);
    localparam logic [LR_W-1:0] LR_MAX = LR_W'(DOWN_CYCLES + 1);
    localparam logic [HR_W-1:0] HR_MAX = HR_W'(HALF_PERIOD + 1);

    logic [LR_W-1:0] low_run_q;
    logic [HR_W-1:0] hi_run_q;
    logic            rst_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q  <= '0;
            hi_run_q   <= '0;
            rst_seen_q <= 1'b0;
        end else begin
            rst_seen_q <= 1'b1;
            if (lps_s)                 low_run_q <= '0;
            else if (low_run_q != LR_MAX) low_run_q <= low_run_q + 1'b1;
            if (!wake_out)             hi_run_q <= '0;
            else if (hi_run_q != HR_MAX)  hi_run_q <= hi_run_q + 1'b1;
        end
    end

    AST_DOWN_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_powered) |-> (low_run_q == LR_W'(DOWN_CYCLES))); // R1

    AST_UP_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        lps_s |=> link_powered); // R2

    AST_IF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (link_if_en == link_powered) && (repeater_only == !link_powered)); // R3

    AST_WAKE_HIGH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run_q <= HR_W'(HALF_PERIOD)); // R4

    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        lps_s |-> !wake_out); // R5

    AST_CONT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen_q |-> $stable(contender_dflt)); // R7

    AST_PCLASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen_q |-> $stable(pwr_class_dflt)); // R8

endmodule

bind link_power_monitor link_power_monitor_chk #(
    .DOWN_CYCLES (DOWN_CYCLES),
    .HALF_PERIOD (HALF_PERIOD)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lps_s          (lps_sync),
    .link_powered   (link_powered),
    .link_if_en     (link_if_en),
    .repeater_only  (repeater_only),
    .wake_out       (wake_out),
    .contender_dflt (contender_dflt),
    .pwr_class_dflt (pwr_class_dflt)
);

// File: tb/link_power_monitor_test.sv
module link_power_monitor_test;

    localparam int D    = 16;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lps_in = 1'b0;
    logic       wake_req = 1'b0;
    logic       wake_cancel = 1'b0;
    logic       wake_pin_in = 1'b0;
    logic [2:0] pwr_class_strap = 3'b000;
    logic       wake_out, wake_oe, link_powered, link_if_en, repeater_only;
    logic       contender_dflt;
    logic [2:0] pwr_class_dflt;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    link_power_monitor #(.DOWN_CYCLES(D), .HALF_PERIOD(HALF)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .lps_in          (lps_in),
        .wake_req        (wake_req),
        .wake_cancel     (wake_cancel),
        .wake_pin_in     (wake_pin_in),
        .pwr_class_strap (pwr_class_strap),
        .wake_out        (wake_out),
        .wake_oe         (wake_oe),
        .link_powered    (link_powered),
        .link_if_en      (link_if_en),
        .repeater_only   (repeater_only),
        .contender_dflt  (contender_dflt),
        .pwr_class_dflt  (pwr_class_dflt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            finish_run();
        end
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic cont, input logic [2:0] pc);
        @(negedge clk);
        rst_n = 1'b0;
        lps_in = 1'b0;
        wake_req = 1'b0;
        wake_cancel = 1'b0;
        wake_pin_in = cont;
        pwr_class_strap = pc;
        edges(3);
        chk("R9 oe in reset", int'(wake_oe), 0);
        rst_n = 1'b1;
        edges(1);
        chk("R9 oe after reset", int'(wake_oe), 1);
        chk("R9 powered after reset", int'(link_powered), 0);
        chk("R3 if_en after reset", int'(link_if_en), 0);
        chk("R3 repeater after reset", int'(repeater_only), 1);
    endtask

    task automatic bring_up();
        lps_in = 1'b1;
        edges(3);
    endtask

    initial begin
        // R7 R8: strap sweep, including changes after reset
        for (int v = 0; v < 16; v++) begin
            do_reset(v[3], v[2:0]);
            chk("R7 contender", int'(contender_dflt), v >> 3);
            chk("R8 pclass", int'(pwr_class_dflt), v & 7);
            wake_pin_in = ~v[3];
            pwr_class_strap = ~v[2:0];
            edges(3);
            chk("R7 contender held", int'(contender_dflt), v >> 3);
            chk("R8 pclass held", int'(pwr_class_dflt), v & 7);
        end

        // R2: rise timing
        do_reset(1'b0, 3'd0);
        lps_in = 1'b1;
        edges(1);
        chk("R2 after 1 edge", int'(link_powered), 0);
        edges(1);
        chk("R2 after 2 edges", int'(link_powered), 0);
        edges(1);
        chk("R2 after 3 edges", int'(link_powered), 1);
        chk("R3 if_en up", int'(link_if_en), 1);
        chk("R3 repeater up", int'(repeater_only), 0);

        // R1: low runs shorter than D never clear the flag
        for (int len = 1; len < D; len++) begin
            lps_in = 1'b0;
            edges(len);
            lps_in = 1'b1;
            edges(3);
            chk("R1 short low run", int'(link_powered), 1);
        end

        // R1: exact fall edge
        lps_in = 1'b0;
        edges(D + 1);
        chk("R1 before fall", int'(link_powered), 1);
        edges(1);
        chk("R1 at fall", int'(link_powered), 0);
        chk("R3 repeater down", int'(repeater_only), 1);

        // R4: waveform
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        for (int k = 0; k < 24; k++) begin
            chk("R4 wave", int'(wake_out), ((k % (2 * HALF)) < HALF) ? 1 : 0);
            @(negedge clk);
        end

        // R6: cancel
        wake_cancel = 1'b1;
        @(negedge clk);
        wake_cancel = 1'b0;
        for (int k = 0; k < 10; k++) begin
            chk("R6 cancel", int'(wake_out), 0);
            @(negedge clk);
        end

        // R5 R6: rising power status forces low and stops the wave
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        chk("R4 restart", int'(wake_out), 1);
        lps_in = 1'b1;
        edges(2);
        chk("R5 forced low", int'(wake_out), 0);
        lps_in = 1'b0;
        for (int k = 0; k < 10; k++) begin
            edges(1);
            chk("R6 stopped by power", int'(wake_out), 0);
        end

        // R4: request ignored while link is powered (low for < D cycles)
        bring_up();
        lps_in = 1'b0;
        edges(3);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        for (int k = 0; k < 8; k++) begin
            chk("R4 ignored when powered", int'(wake_out), 0);
            @(negedge clk);
        end

        finish_run();
    end

endmodule